// File: doc/BRIEF.md
# Code Bank Switch Controller

This block picks which bank of code memory an 8051-style core fetches from. It keeps the current bank number in a register and drives it onto the upper code-address lines. It also keeps a private hardware stack of bank numbers. The core's instruction decoder sends one-cycle strobes for long call, long jump, absolute call, return, interrupt acknowledge and return from interrupt. When automatic switching is on, those strobes push the current bank onto the stack or pop it back, so the bank follows the program flow with no help from software.

Software reaches the block through a small special-function-register port with three addresses. The select register holds a pending bank that the next long call or long jump takes up. The stack register lets software push and pop bank numbers directly, which is how it builds indirect calls. The control register holds the enable bit and two sticky error flags. While switching is disabled, flow strobes are ignored, so legacy code that handles banks by hand keeps working. The port is a plain register interface with no back-pressure. A read is taken in the cycle `sfr_rd` is high, and the value appears on `sfr_rdata` from the next cycle on.

Top module: `codebank_ctrl`

## Requirements
- R1: After reset, `code_bank` is 0, the pending bank is 0, the bank stack is empty, and automatic switching is off. A read of the control register (address 2) returns 0.
- R2: A write to the select register (address 0) only stores `sfr_wdata` as the pending bank. It leaves `code_bank` and the stack unchanged. A read of address 0 returns the current bank, not the pending one.
- R3: With switching on, a long call or long jump strobe pushes the current bank onto the stack. The pending bank becomes `code_bank` on the next cycle.
- R4: With switching on, an absolute call strobe pushes the current bank onto the stack and leaves `code_bank` unchanged.
- R5: With switching on, a return or return-from-interrupt strobe pops the top of the stack into `code_bank`.
- R6: With switching on, an interrupt acknowledge strobe pushes the current bank and makes `code_bank` 0, whatever the pending bank holds. If several strobes arrive together, interrupt acknowledge wins. The order after it is long call/jump, then absolute call, then return.
- R7: With switching off (control bit 0 clear), flow strobes change neither `code_bank` nor the stack.
- R8: A write to the stack register (address 1) pushes `sfr_wdata`. A read of address 1 pops the top entry and returns it. `sfr_rdata` keeps its value in every cycle without a read.
- R9: The stack holds 16 entries. A push onto a full stack drops the value and sets a sticky overflow flag, read as control bit 1. Writing 1 to bit 1 clears the flag. Control bit 0 is written as the enable.
- R10: A pop from an empty stack returns bank 0 and sets a sticky underflow flag, read as control bit 2. Writing 1 to bit 2 clears the flag.
- R11: When a register access falls in the same cycle as a flow strobe, the strobe's effect is applied first and the access sees the result. A control write that clears a flag therefore wins over a flag set by that cycle's strobe. If `sfr_wr` and `sfr_rd` are both high, only the write is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_lcall | input | 1 | Long call strobe |
| ev_ljmp | input | 1 | Long jump strobe |
| ev_acall | input | 1 | Absolute call strobe |
| ev_ret | input | 1 | Return strobe |
| ev_intack | input | 1 | Interrupt acknowledge strobe |
| ev_reti | input | 1 | Return-from-interrupt strobe |
| sfr_wr | input | 1 | Register write |
| sfr_rd | input | 1 | Register read |
| sfr_addr | input | 2 | 0 select, 1 stack, 2 control |
| sfr_wdata | input | BANK_W | Write data |
| sfr_rdata | output | BANK_W | Read data, updated the cycle after a read |
| code_bank | output | BANK_W | Current bank, upper code address bits [19:16] |

## Verification
A flow strobe and a register access can fall in the same cycle. The hard cases are an absolute call together with a stack pop, which must hand back the bank the call just pushed, and a long jump together with a select write, which must take up the old pending value. The directed part of the bench sets up both pairings on purpose. A randomized phase then lets strobes (several at once) and accesses overlap freely. Each cycle is judged against a behavioural model that applies the strobe first and the access second.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [1:0] {STK_NONE = 2'd0, STK_PUSH = 2'd1, STK_POP = 2'd2} stk_op_e;
  typedef enum logic [1:0] {SRC_KEEP = 2'd0, SRC_ZERO = 2'd1, SRC_PEND = 2'd2, SRC_POPPED = 2'd3} cur_src_e;
  localparam logic [1:0] ADDR_SEL = 2'd0;
  localparam logic [1:0] ADDR_STK = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
endpackage

// File: rtl/cbs_flow_decode.sv
module cbs_flow_decode
  import cbs_pkg::*;
(
  input  logic     en,
  input  logic     ev_lcall,
  input  logic     ev_ljmp,
  input  logic     ev_acall,
  input  logic     ev_ret,
  input  logic     ev_intack,
  input  logic     ev_reti,
  output stk_op_e  op,
  output cur_src_e src
);
  // Priority: interrupt, long call/jump, absolute call, return.
  always_comb begin
    op  = STK_NONE;
    src = SRC_KEEP;
    if (en) begin
      if (ev_intack) begin
        op  = STK_PUSH;
        src = SRC_ZERO;
      end else if (ev_lcall || ev_ljmp) begin
        op  = STK_PUSH;
        src = SRC_PEND;
      end else if (ev_acall) begin
        op  = STK_PUSH;
        src = SRC_KEEP;
      end else if (ev_ret || ev_reti) begin
        op  = STK_POP;
        src = SRC_POPPED;
      end
    end
  end
endmodule

// File: rtl/cbs_bank_stack.sv
module cbs_bank_stack
  import cbs_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 16,
  parameter int NOPS  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_op_e       op       [NOPS],
  input  logic [W-1:0]  din      [NOPS],
  output logic [W-1:0]  pop_data [NOPS],
  output logic [NOPS-1:0] ovf_hit,
  output logic [NOPS-1:0] udf_hit
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [W-1:0]  mem_n [DEPTH];
  logic [PW-1:0] sp_q, sp_n;

  // Operations are applied in index order within one cycle.
  always_comb begin
    mem_n   = mem_q;
    sp_n    = sp_q;
    ovf_hit = '0;
    udf_hit = '0;
    for (int k = 0; k < NOPS; k++) begin
      pop_data[k] = '0;
      if (op[k] == STK_PUSH) begin
        if (sp_n == PW'(DEPTH)) begin
          ovf_hit[k] = 1'b1;
        end else begin
          mem_n[sp_n[IW-1:0]] = din[k];
          sp_n = sp_n + PW'(1);
        end
      end else if (op[k] == STK_POP) begin
        if (sp_n == '0) begin
          udf_hit[k] = 1'b1;
        end else begin
          sp_n = sp_n - PW'(1);
          pop_data[k] = mem_n[sp_n[IW-1:0]];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      sp_q  <= sp_n;
      mem_q <= mem_n;
    end
  end
endmodule

// File: rtl/codebank_ctrl.sv
module codebank_ctrl
  import cbs_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_lcall,
  input  logic              ev_ljmp,
  input  logic              ev_acall,
  input  logic              ev_ret,
  input  logic              ev_intack,
  input  logic              ev_reti,
  input  logic              sfr_wr,
  input  logic              sfr_rd,
  input  logic [1:0]        sfr_addr,
  input  logic [BANK_W-1:0] sfr_wdata,
  output logic [BANK_W-1:0] sfr_rdata,
  output logic [BANK_W-1:0] code_bank
);
  localparam int NOPS = 2;
  localparam int EV   = 0;
  localparam int SW   = 1;

  logic [BANK_W-1:0] cur_q, pend_q, rdata_q;
  logic              en_q, ovf_q, udf_q;

  stk_op_e           st_op   [NOPS];
  logic [BANK_W-1:0] st_din  [NOPS];
  logic [BANK_W-1:0] st_pop  [NOPS];
  logic [NOPS-1:0]   st_ovf, st_udf;
  stk_op_e           ev_op;
  cur_src_e          ev_src;

  logic              do_wr, do_rd;
  logic [BANK_W-1:0] cur_ev;
  logic              ovf_ev, udf_ev;

  assign do_wr = sfr_wr;
  assign do_rd = sfr_rd && !sfr_wr;

  cbs_flow_decode u_dec (
    .en        (en_q),
    .ev_lcall  (ev_lcall),
    .ev_ljmp   (ev_ljmp),
    .ev_acall  (ev_acall),
    .ev_ret    (ev_ret),
    .ev_intack (ev_intack),
    .ev_reti   (ev_reti),
    .op        (ev_op),
    .src       (ev_src)
  );

  // Port 0 carries the flow event, port 1 the register access after it.
  always_comb begin
    st_op[EV]  = ev_op;
    st_din[EV] = cur_q;
    st_din[SW] = sfr_wdata;
    if (do_wr && sfr_addr == ADDR_STK)      st_op[SW] = STK_PUSH;
    else if (do_rd && sfr_addr == ADDR_STK) st_op[SW] = STK_POP;
    else                                    st_op[SW] = STK_NONE;
  end

  cbs_bank_stack #(.W(BANK_W), .DEPTH(DEPTH), .NOPS(NOPS)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (st_op),
    .din      (st_din),
    .pop_data (st_pop),
    .ovf_hit  (st_ovf),
    .udf_hit  (st_udf)
  );

  always_comb begin
    unique case (ev_src)
      SRC_ZERO:   cur_ev = '0;
      SRC_PEND:   cur_ev = pend_q;
      SRC_POPPED: cur_ev = st_pop[EV];
      default:    cur_ev = cur_q;
    endcase
  end

  assign ovf_ev = ovf_q | st_ovf[EV];
  assign udf_ev = udf_q | st_udf[EV];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '0;
      pend_q  <= '0;
      rdata_q <= '0;
      en_q    <= 1'b0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      cur_q <= cur_ev;
      ovf_q <= (ovf_ev | st_ovf[SW]) & ~(do_wr && sfr_addr == ADDR_CTL && sfr_wdata[1]);
      udf_q <= (udf_ev | st_udf[SW]) & ~(do_wr && sfr_addr == ADDR_CTL && sfr_wdata[2]);
      if (do_wr && sfr_addr == ADDR_SEL) pend_q <= sfr_wdata;
      if (do_wr && sfr_addr == ADDR_CTL) en_q <= sfr_wdata[0];
      if (do_rd) begin
        unique case (sfr_addr)
          ADDR_SEL: rdata_q <= cur_ev;
          ADDR_STK: rdata_q <= st_pop[SW];
          ADDR_CTL: rdata_q <= BANK_W'({udf_ev, ovf_ev, en_q});
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign code_bank = cur_q;
  assign sfr_rdata = rdata_q;
endmodule

// File: rtl/codebank_ctrl_chk.sv
module codebank_ctrl_chk #(
  parameter int BANK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_lcall,
  input logic              ev_ljmp,
  input logic              ev_acall,
  input logic              ev_ret,
  input logic              ev_intack,
  input logic              ev_reti,
  input logic              sfr_wr,
  input logic              sfr_rd,
  input logic [1:0]        sfr_addr,
  input logic              clr_ovf_bit,
  input logic [BANK_W-1:0] sfr_rdata,
  input logic [BANK_W-1:0] code_bank,
  input logic              en_q,
  input logic              ovf_q,
  input logic [BANK_W-1:0] pend_q
);
  logic any_ev;
  assign any_ev = ev_lcall | ev_ljmp | ev_acall | ev_ret | ev_intack | ev_reti;

  assert_intack_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && ev_intack) |=> (code_bank == '0));

  assert_long_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !ev_intack && (ev_lcall || ev_ljmp)) |=> (code_bank == $past(pend_q)));

  assert_acall_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && ev_acall && !ev_intack && !ev_lcall && !ev_ljmp) |=> $stable(code_bank));

  assert_off_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(code_bank));

  assert_sel_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == 2'd0 && !any_ev) |=> $stable(code_bank));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(sfr_wr && sfr_addr == 2'd2 && clr_ovf_bit)) |=> ovf_q);

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_rd |=> $stable(sfr_rdata));
endmodule

bind codebank_ctrl codebank_ctrl_chk #(.BANK_W(BANK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_lcall    (ev_lcall),
  .ev_ljmp     (ev_ljmp),
  .ev_acall    (ev_acall),
  .ev_ret      (ev_ret),
  .ev_intack   (ev_intack),
  .ev_reti     (ev_reti),
  .sfr_wr      (sfr_wr),
  .sfr_rd      (sfr_rd),
  .sfr_addr    (sfr_addr),
  .clr_ovf_bit (sfr_wdata[1]),
  .sfr_rdata   (sfr_rdata),
  .code_bank   (code_bank),
  .en_q        (en_q),
  .ovf_q       (ovf_q),
  .pend_q      (pend_q)
);

// File: tb/codebank_ctrl_bench.sv
module codebank_ctrl_bench;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_lcall = 0, ev_ljmp = 0, ev_acall = 0, ev_ret = 0, ev_intack = 0, ev_reti = 0;
  logic sfr_wr = 0, sfr_rd = 0;
  logic [1:0] sfr_addr = '0;
  logic [BW-1:0] sfr_wdata = '0;
  wire  [BW-1:0] sfr_rdata;
  wire  [BW-1:0] code_bank;

  always #5 clk = ~clk;

  codebank_ctrl u_codebank_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ev_lcall(ev_lcall), .ev_ljmp(ev_ljmp), .ev_acall(ev_acall),
    .ev_ret(ev_ret), .ev_intack(ev_intack), .ev_reti(ev_reti),
    .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .code_bank(code_bank)
  );

  // Behavioural reference
  int m_stack[$];
  int m_cur = 0, m_pend = 0, m_rdata = 0;
  bit m_en = 0, m_ovf = 0, m_udf = 0;
  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  function automatic void mpush(int v);
    if (m_stack.size() == 16) m_ovf = 1;
    else m_stack.push_back(v);
  endfunction

  function automatic int mpop();
    if (m_stack.size() == 0) begin
      m_udf = 1;
      return 0;
    end
    return m_stack.pop_back();
  endfunction

  function automatic void model_cycle();
    if (m_en) begin
      if (ev_intack) begin mpush(m_cur); m_cur = 0; end
      else if (ev_lcall || ev_ljmp) begin mpush(m_cur); m_cur = m_pend; end
      else if (ev_acall) mpush(m_cur);
      else if (ev_ret || ev_reti) m_cur = mpop();
    end
    if (sfr_wr) begin
      case (sfr_addr)
        2'd0: m_pend = int'(sfr_wdata);
        2'd1: mpush(int'(sfr_wdata));
        2'd2: begin
          m_en = sfr_wdata[0];
          if (sfr_wdata[1]) m_ovf = 0;
          if (sfr_wdata[2]) m_udf = 0;
        end
        default: ;
      endcase
    end else if (sfr_rd) begin
      case (sfr_addr)
        2'd0: m_rdata = m_cur;
        2'd1: m_rdata = mpop();
        2'd2: m_rdata = (int'(m_udf) << 2) | (int'(m_ovf) << 1) | int'(m_en);
        default: m_rdata = 0;
      endcase
    end
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {ev_lcall, ev_ljmp, ev_acall, ev_ret, ev_intack, ev_reti} = '0;
    sfr_wr = 0; sfr_rd = 0; sfr_addr = '0; sfr_wdata = '0;
  endtask

  // Inputs are set at the falling edge; model runs after the rising edge.
  task automatic step(string tag);
    @(posedge clk);
    #1;
    if (rst_n) model_cycle();
    @(negedge clk);
    check(tag, "code_bank", int'(code_bank), m_cur);
    check(tag, "sfr_rdata", int'(sfr_rdata), m_rdata);
    idle_inputs();
  endtask

  task automatic wr(string tag, int a, int d);
    sfr_wr = 1; sfr_addr = 2'(a); sfr_wdata = BW'(d);
    step(tag);
  endtask

  task automatic rd(string tag, int a);
    sfr_rd = 1; sfr_addr = 2'(a);
    step(tag);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1", "reset code_bank", int'(code_bank), 0);
    check("R1", "reset sfr_rdata", int'(sfr_rdata), 0);
    rst_n = 1;
    rd("R1", 2);                              // control reads 0

    // R7: disabled switching ignores flow strobes
    wr("R7", 0, 5);
    ev_lcall = 1; step("R7");
    ev_intack = 1; step("R7");
    ev_ret = 1; step("R7");
    rd("R7", 1);                              // stack untouched: empty pop -> 0
    rd("R10", 2);                             // underflow flag set (bit 2)
    wr("R10", 2, 4);                          // clear underflow, stay disabled
    rd("R10", 2);

    // R2: select write is pending only
    wr("R2", 0, 7);
    rd("R2", 0);                              // current bank still 0
    wr("R9", 2, 1);                           // enable

    ev_lcall = 1; step("R3");                 // bank -> 7
    rd("R2", 0);
    ev_acall = 1; step("R4");                 // bank stays 7
    wr("R3", 0, 3);
    ev_ljmp = 1; step("R3");                  // bank -> 3
    ev_ret = 1; step("R5");                   // -> 7
    ev_reti = 1; step("R5");                  // -> 7
    ev_ret = 1; step("R5");                   // -> 0

    wr("R6", 0, 9);
    ev_lcall = 1; step("R6");                 // bank 9
    ev_intack = 1; ev_lcall = 1; step("R6");  // interrupt wins -> 0
    ev_reti = 1; step("R6");                  // back to 9
    ev_ret = 1; step("R5");                   // back to 0

    // R8: software push/pop
    wr("R8", 1, 10);
    wr("R8", 1, 5);
    rd("R8", 1);
    step("R8");                               // rdata holds
    rd("R8", 1);

    // R9: overflow
    for (int i = 0; i < 17; i++) wr("R9", 1, i);
    rd("R9", 2);
    for (int i = 0; i < 16; i++) rd("R9", 1);
    wr("R9", 2, 3);                           // clear overflow, keep enable
    rd("R9", 2);

    // R10: underflow via flow pop
    ev_ret = 1; step("R10");
    rd("R10", 2);
    wr("R10", 2, 5);

    // R11: same-cycle ordering
    wr("R11", 0, 6);
    ev_lcall = 1; step("R11");                // bank 6
    ev_acall = 1; sfr_rd = 1; sfr_addr = 2'd1; step("R11"); // pops the 6 just pushed
    wr("R11", 0, 2);
    ev_ljmp = 1; sfr_wr = 1; sfr_addr = 2'd0; sfr_wdata = 4'd11; step("R11"); // takes 2
    ev_ret = 1; sfr_rd = 1; sfr_addr = 2'd0; step("R11");
    ev_ret = 1; sfr_wr = 1; sfr_addr = 2'd2; sfr_wdata = 4'd5; step("R11"); // clear wins
    rd("R11", 2);

    // Randomized overlap
    for (int n = 0; n < 3000; n++) begin
      ev_lcall  = ($urandom_range(0, 9) == 0);
      ev_ljmp   = ($urandom_range(0, 9) == 0);
      ev_acall  = ($urandom_range(0, 7) == 0);
      ev_ret    = ($urandom_range(0, 5) == 0);
      ev_intack = ($urandom_range(0, 15) == 0);
      ev_reti   = ($urandom_range(0, 9) == 0);
      sfr_wr    = ($urandom_range(0, 3) == 0);
      sfr_rd    = ($urandom_range(0, 3) == 0);
      sfr_addr  = 2'($urandom_range(0, 3));
      sfr_wdata = BW'($urandom_range(0, 15));
      if (sfr_wr && sfr_addr == 2'd2) sfr_wdata[0] = ($urandom_range(0, 7) != 0);
      step("R11");
    end

    done = 1;
    finish_run();
  end
endmodule